// File: doc/BRIEF.md
# Descriptor Ring Queue Controller

This block keeps the bookkeeping for a circular queue of fixed-size command descriptors that a host fills and a processing engine drains. The descriptors themselves sit in memory outside the block. Only indices and counts live here. The host programs the ring length and the slot format through a small word-addressed register port. To queue work, it reads the next free slot index, writes its descriptors into memory, and then writes how many it added. Once the engine has finished them, the host reads the completed count and the index of the oldest finished slot, then hands those slots back by writing a release count.

Toward the engine, the block offers one slot index at a time on a valid/ready channel. The engine accepts the index, works on the descriptor, and reports the end of that work with a one-cycle done pulse. The offer is registered. Once `desc_valid` rises, it stays high and `desc_slot` stays unchanged until the cycle in which `desc_ready` is high. The engine may hold `desc_ready` low for any length of time. No new offer appears until the accepted descriptor has been reported done. A level interrupt tells the host that completed work is waiting, and a threshold register can mask it. Any request the block refuses sets a sticky error flag.

Register map (3-bit word address): 0 ring length, 1 slot format, 2 next free index (read), 3 add count (write), 4 completion status (read), 5 release count (write), 6 interrupt threshold, 7 run/status.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset, the registers read as follows: ring length 1024, slot format code 7, next free index 0, completion status 0, run/status 0. The `irq` and `desc_valid` outputs are low.
- R2: A write to address 0 takes effect only when all three conditions hold: the value is at least 1, it does not exceed the cap of the current format, and the ring holds no outstanding descriptor. The caps are 16384 slots for code 1 and 4096 slots for code 7. An accepted write resets every index and count to 0. A refused write leaves the length unchanged and sets the error flag.
- R3: A write to address 1 accepts only code 1 (32-byte slots) or code 7 (128-byte slots). It also requires that the current length fits the new code's cap and that the ring is empty. Any other write is refused, leaves the format unchanged and sets the error flag.
- R4: A read of address 2 returns the next free slot index in bits [29:16], with all other bits 0.
- R5: A write of N (bits [14:0]) to address 3 is accepted only when the following sum does not exceed the ring length: queued descriptors, plus the one in flight, plus the completed descriptors, plus N. When accepted, the next free index advances by N modulo the ring length. When refused, nothing changes and the error flag is set.
- R6: The engine is offered slot indices in ring order, starting at 0 after reset or after a length change. An offer holds its index stable until accepted. After a handshake, no further offer appears until the done pulse for that descriptor.
- R7: Writing 0 to address 7 sets the block running, and writing any non-zero value stops it. No new offer is raised while the block is stopped or while nothing is queued.
- R8: A `desc_done` pulse while a descriptor is in flight adds one to the completed count. A pulse while nothing is in flight is ignored.
- R9: A read of address 4 returns the completed-but-unreleased count in bits [14:0] and the index of the oldest such slot in bits [29:16].
- R10: A write of N to address 5 is accepted when N is at most the completed count. When accepted, the count drops by N and the oldest-completed index advances by N modulo the ring length. A larger N is refused, changes nothing and sets the error flag.
- R11: `irq` is high exactly when the completed count is non-zero and greater than the threshold held in bits [14:0] of address 6.
- R12: The error flag reads back in bit 1 of address 7, and the run state reads back in bit 0. Once set, the error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (for both write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| desc_valid | output | 1 | A slot index is offered to the engine |
| desc_slot | output | 14 | Offered slot index |
| desc_ready | input | 1 | Engine accepts the offered slot |
| desc_done | input | 1 | One-cycle pulse: the in-flight descriptor is finished |
| irq | output | 1 | Completion interrupt (level) |

## Verification
The bench configures an 8-slot ring and sweeps add batches of every size from 1 to 8. Each batch is served, then released in full. Across the sweep the producer, issue and completion indices pass the wrap point many times, so an off-by-one in the modulo step shows up as a wrong slot or a wrong status field. A held-back ready separates a stable offer from one that drifts. Stalling before the done pulse separates a single-flight engine port from one that issues ahead. Further patterns cover an add that would overfill the ring, a release larger than the completed count, length and format writes that must be refused, a done pulse with nothing in flight, and threshold values on both sides of the completed count.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

  typedef enum logic [2:0] {
    RA_SIZE    = 3'd0,
    RA_FMT     = 3'd1,
    RA_NEXT    = 3'd2,
    RA_POST    = 3'd3,
    RA_DONE    = 3'd4,
    RA_RELEASE = 3'd5,
    RA_LEVEL   = 3'd6,
    RA_RUN     = 3'd7
  } reg_addr_e;

  localparam logic [2:0] FMT_SMALL = 3'd1;  // 32-byte slots
  localparam logic [2:0] FMT_LARGE = 3'd7;  // 128-byte slots

  // advance a ring index by n, with idx < size and n <= size
  function automatic logic [31:0] ring_step(input logic [31:0] idx,
                                            input logic [31:0] n,
                                            input logic [31:0] size);
    logic [31:0] s;
    s = idx + n;
    if (s >= size) s = s - size;
    return s;
  endfunction

endpackage

// File: rtl/ring_cfg.sv
module ring_cfg
  import desc_ring_pkg::*;
#(
  parameter int IDX_W       = 14,
  parameter int CNT_W       = IDX_W + 1,
  parameter int RESET_SLOTS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_addr_e        wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             ring_empty,
  output logic [CNT_W-1:0] slots,
  output logic [2:0]       fmt,
  output logic [CNT_W-1:0] level,
  output logic             run,
  output logic             clear,
  output logic             reject
);

  localparam logic [CNT_W-1:0] CAP_SMALL = CNT_W'(1) << IDX_W;
  localparam logic [CNT_W-1:0] CAP_LARGE = CNT_W'(1) << (IDX_W - 2);

  function automatic logic [CNT_W-1:0] cap_of(input logic [2:0] code);
    return (code == FMT_SMALL) ? CAP_SMALL : CAP_LARGE;
  endfunction

  logic [CNT_W-1:0] new_size;
  logic [2:0]       new_fmt;
  logic             size_hit, fmt_hit, size_ok, fmt_ok;

  assign new_size = wr_data[CNT_W-1:0];
  assign new_fmt  = wr_data[2:0];
  assign size_hit = wr_en && (wr_addr == RA_SIZE);
  assign fmt_hit  = wr_en && (wr_addr == RA_FMT);

  assign size_ok = (wr_data[31:CNT_W] == '0) && (new_size != '0) &&
                   (new_size <= cap_of(fmt)) && ring_empty;
  assign fmt_ok  = (wr_data[31:3] == '0) &&
                   ((new_fmt == FMT_SMALL) || (new_fmt == FMT_LARGE)) &&
                   (slots <= cap_of(new_fmt)) && ring_empty;

  assign clear  = size_hit && size_ok;
  assign reject = (size_hit && !size_ok) || (fmt_hit && !fmt_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots <= CNT_W'(RESET_SLOTS);
      fmt   <= FMT_LARGE;
      level <= '0;
      run   <= 1'b0;
    end else begin
      if (size_hit && size_ok) slots <= new_size;
      if (fmt_hit && fmt_ok)   fmt   <= new_fmt;
      if (wr_en && (wr_addr == RA_LEVEL)) level <= wr_data[CNT_W-1:0];
      if (wr_en && (wr_addr == RA_RUN))   run   <= (wr_data == 32'd0);
    end
  end

  assert_slots_capped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slots != '0) && (slots <= cap_of(fmt)));

endmodule

// File: rtl/ring_ptrs.sv
module ring_ptrs
  import desc_ring_pkg::*;
#(
  parameter int IDX_W = 14,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] slots,
  input  logic             clear,
  input  logic             post_en,
  input  logic             rel_en,
  input  logic [CNT_W-1:0] count,
  input  logic             hs,
  input  logic             busy,
  input  logic             done_ok,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] queued,
  output logic [CNT_W-1:0] done_cnt,
  output logic             reject,
  output logic             empty
);

  localparam int SUM_W = CNT_W + 2;

  logic [SUM_W-1:0] outst;
  logic             post_acc, rel_acc;
  logic [31:0]      wr_nxt, rd_nxt;

  assign outst    = SUM_W'(queued) + SUM_W'(busy) + SUM_W'(done_cnt);
  assign post_acc = post_en && ((outst + SUM_W'(count)) <= SUM_W'(slots));
  assign rel_acc  = rel_en && (count <= done_cnt);
  assign reject   = (post_en && !post_acc) || (rel_en && !rel_acc);
  assign empty    = (outst == '0);

  assign wr_nxt = ring_step(32'(wr_idx), 32'(count), 32'(slots));
  assign rd_nxt = ring_step(32'(rd_idx), 32'(count), 32'(slots));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx   <= '0;
      rd_idx   <= '0;
      queued   <= '0;
      done_cnt <= '0;
    end else if (clear) begin
      wr_idx   <= '0;
      rd_idx   <= '0;
      queued   <= '0;
      done_cnt <= '0;
    end else begin
      if (post_acc) wr_idx <= wr_nxt[IDX_W-1:0];
      if (rel_acc)  rd_idx <= rd_nxt[IDX_W-1:0];
      queued   <= queued + (post_acc ? count : '0) - CNT_W'(hs);
      done_cnt <= done_cnt + CNT_W'(done_ok) - (rel_acc ? count : '0);
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= SUM_W'(slots));

  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(wr_idx) < slots) && (CNT_W'(rd_idx) < slots));

  assert_release_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && (count > done_cnt) && !clear) |=> (done_cnt >= $past(done_cnt)));

endmodule

// File: rtl/ring_issue.sv
module ring_issue
  import desc_ring_pkg::*;
#(
  parameter int IDX_W = 14,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] slots,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] queued,
  input  logic             ready,
  input  logic             done_in,
  output logic             valid,
  output logic [IDX_W-1:0] slot,
  output logic             busy,
  output logic             hs,
  output logic             done_ok
);

  logic [31:0] slot_nxt;

  assign hs       = valid && ready;
  assign done_ok  = done_in && busy;
  assign slot_nxt = ring_step(32'(slot), 32'd1, 32'(slots));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      busy  <= 1'b0;
      slot  <= '0;
    end else begin
      if (clear) slot <= '0;
      if (hs) begin
        valid <= 1'b0;
        busy  <= 1'b1;
        slot  <= slot_nxt[IDX_W-1:0];
      end else if (!valid && !busy && run && (queued != '0)) begin
        valid <= 1'b1;
      end
      if (done_ok) busy <= 1'b0;
    end
  end

  assert_offer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(slot)));

  assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !valid) |=> !valid);

endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int IDX_W       = 14,
  parameter int RESET_SLOTS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             desc_valid,
  output logic [IDX_W-1:0] desc_slot,
  input  logic             desc_ready,
  input  logic             desc_done,
  output logic             irq
);

  localparam int CNT_W = IDX_W + 1;

  reg_addr_e        addr_e;
  logic [CNT_W-1:0] slots, level, queued, done_cnt;
  logic [2:0]       fmt;
  logic             run, clear, cfg_rej, ptr_rej, empty;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             hs, busy, done_ok, err;

  assign addr_e = reg_addr_e'(reg_addr);

  ring_cfg #(.IDX_W(IDX_W), .CNT_W(CNT_W), .RESET_SLOTS(RESET_SLOTS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(addr_e),
    .wr_data(reg_wdata), .ring_empty(empty), .slots(slots), .fmt(fmt),
    .level(level), .run(run), .clear(clear), .reject(cfg_rej));

  ring_ptrs #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .slots(slots), .clear(clear),
    .post_en(reg_wr && (addr_e == RA_POST)),
    .rel_en(reg_wr && (addr_e == RA_RELEASE)),
    .count(reg_wdata[CNT_W-1:0]), .hs(hs), .busy(busy), .done_ok(done_ok),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .queued(queued), .done_cnt(done_cnt),
    .reject(ptr_rej), .empty(empty));

  ring_issue #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .slots(slots), .clear(clear), .run(run),
    .queued(queued), .ready(desc_ready), .done_in(desc_done),
    .valid(desc_valid), .slot(desc_slot), .busy(busy), .hs(hs),
    .done_ok(done_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err | cfg_rej | ptr_rej;
  end

  assign irq = (done_cnt != '0) && (done_cnt > level);

  always_comb begin
    reg_rdata = '0;
    case (addr_e)
      RA_SIZE:  reg_rdata[CNT_W-1:0] = slots;
      RA_FMT:   reg_rdata[2:0] = fmt;
      RA_NEXT:  reg_rdata[16 +: IDX_W] = wr_idx;
      RA_DONE: begin
        reg_rdata[CNT_W-1:0]   = done_cnt;
        reg_rdata[16 +: IDX_W] = rd_idx;
      end
      RA_LEVEL: reg_rdata[CNT_W-1:0] = level;
      RA_RUN:   reg_rdata[1:0] = {err, run};
      default:  reg_rdata = '0;
    endcase
  end

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: tb/desc_ring_ctrl_test.sv
module desc_ring_ctrl_test;
  localparam int IW = 14;

  logic          clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          desc_ready = 1'b0, desc_done = 1'b0;
  logic          desc_valid, irq;
  logic [IW-1:0] desc_slot;

  desc_ring_ctrl #(.IDX_W(IW), .RESET_SLOTS(1024)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_valid(desc_valid),
    .desc_slot(desc_slot), .desc_ready(desc_ready), .desc_done(desc_done),
    .irq(irq));

  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0, n_fail = 0;
  bit ended = 0;
  int m_size, m_wr, m_rd, m_iss, m_q, m_done, m_err, m_run;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; desc_ready = 1'b0; desc_done = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_size = 1024; m_wr = 0; m_rd = 0; m_iss = 0; m_q = 0; m_done = 0;
    m_err = 0; m_run = 0;
  endtask

  task automatic chk_status(input string req);
    logic [31:0] d;
    rreg(3'd7, d);
    check(req, d, 32'((m_err << 1) | m_run));
  endtask

  task automatic chk_next(input string req);
    logic [31:0] d;
    rreg(3'd2, d);
    check(req, d, 32'(m_wr) << 16);
  endtask

  task automatic chk_done(input string req);
    logic [31:0] d;
    rreg(3'd4, d);
    check(req, d, (32'(m_rd) << 16) | 32'(m_done));
  endtask

  task automatic post(input int n);
    wreg(3'd3, 32'(n));
    if (m_q + m_done + n <= m_size) begin
      m_q += n; m_wr = (m_wr + n) % m_size;
    end else m_err = 1;
  endtask

  task automatic release_n(input int n);
    wreg(3'd5, 32'(n));
    if (n <= m_done) begin
      m_done -= n; m_rd = (m_rd + n) % m_size;
    end else m_err = 1;
  endtask

  task automatic serve(input int hold);
    int t;
    t = 0;
    while (!desc_valid && t < 40) begin @(negedge clk); t++; end
    check("R6 offer raised", 32'(desc_valid), 32'd1);
    check("R6 slot order", 32'(desc_slot), 32'(m_iss));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R6 offer held", 32'(desc_valid), 32'd1);
      check("R6 slot stable", 32'(desc_slot), 32'(m_iss));
    end
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
    check("R6 offer dropped after handshake", 32'(desc_valid), 32'd0);
    @(negedge clk);
    check("R6 single flight", 32'(desc_valid), 32'd0);
    desc_done = 1'b1;
    @(negedge clk);
    desc_done = 1'b0;
    m_iss = (m_iss + 1) % m_size; m_q--; m_done++;
    chk_done("R8 done counted");
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R1 reset values
    rreg(3'd0, d); check("R1 size", d, 32'd1024);
    rreg(3'd1, d); check("R1 fmt", d, 32'd7);
    chk_next("R1 next free");
    chk_done("R1 completion");
    chk_status("R1 status");
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 valid", 32'(desc_valid), 32'd0);

    // R2 length above large cap refused, R12 sticky
    wreg(3'd0, 32'd5000); m_err = 1;
    rreg(3'd0, d); check("R2 size kept", d, 32'd1024);
    chk_status("R12 err set");
    wreg(3'd6, 32'd1);
    chk_status("R12 err stays");
    wreg(3'd0, 32'd0);
    rreg(3'd0, d); check("R2 zero length refused", d, 32'd1024);

    // R3 format rules
    do_reset();
    wreg(3'd1, 32'd1);
    rreg(3'd1, d); check("R3 fmt small", d, 32'd1);
    wreg(3'd0, 32'd5000);
    rreg(3'd0, d); check("R2 size under small cap", d, 32'd5000);
    chk_status("R3 no err");
    wreg(3'd1, 32'd7); m_err = 1;
    rreg(3'd1, d); check("R3 fmt refused (length over cap)", d, 32'd1);
    chk_status("R3 err");
    do_reset();
    wreg(3'd1, 32'd3); m_err = 1;
    rreg(3'd1, d); check("R3 bad code refused", d, 32'd7);
    chk_status("R3 bad code err");

    // small ring
    do_reset();
    wreg(3'd0, 32'd8); m_size = 8;
    rreg(3'd0, d); check("R2 size 8", d, 32'd8);
    chk_status("R2 no err");

    // R7 stopped: no offer
    post(3);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R7 no offer while stopped", 32'(desc_valid), 32'd0);
    end
    chk_next("R4 next free after add");

    wreg(3'd7, 32'd0); m_run = 1;
    chk_status("R12 run bit");
    serve(3);
    serve(0);
    serve(1);
    check("R11 irq with threshold 0", 32'(irq), 32'd1);
    wreg(3'd6, 32'd3);
    check("R11 irq masked at equal", 32'(irq), 32'd0);
    wreg(3'd6, 32'd2);
    check("R11 irq above threshold", 32'(irq), 32'd1);
    wreg(3'd6, 32'd0);

    release_n(2); chk_done("R10 release 2");
    release_n(1); chk_done("R10 release 1");
    check("R11 irq low when empty", 32'(irq), 32'd0);

    // R8 stray done ignored
    @(negedge clk); desc_done = 1'b1;
    @(negedge clk); desc_done = 1'b0;
    chk_done("R8 stray done ignored");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 no offer when empty", 32'(desc_valid), 32'd0);
    end

    // R5/R9 sweep of batch sizes, wrapping the ring
    for (int k = 1; k <= 8; k++) begin
      post(k);
      chk_next("R4 R5 next free wraps");
      for (int j = 0; j < k; j++) serve(j % 2);
      chk_done("R9 completion fields");
      check("R11 irq pending", 32'(irq), 32'd1);
      release_n(k);
      chk_done("R10 release wraps");
      check("R11 irq cleared", 32'(irq), 32'd0);
    end
    chk_status("R12 no err after sweep");

    // R5 overflow refused
    wreg(3'd7, 32'd1); m_run = 0;
    post(5);
    post(4);
    chk_next("R5 overflow index kept");
    chk_status("R5 overflow err");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 stopped no offer", 32'(desc_valid), 32'd0);
    end
    // R2 length refused when not empty
    wreg(3'd0, 32'd4);
    rreg(3'd0, d); check("R2 busy ring keeps length", d, 32'd8);
    wreg(3'd7, 32'd0); m_run = 1;
    for (int j = 0; j < 5; j++) serve(0);
    // R10 over-release refused
    release_n(9);
    chk_done("R10 over-release ignored");
    release_n(5);
    chk_done("R10 release after refusal");
    chk_status("R12 err still set");

    finish_run();
  end
endmodule